// File: doc/BRIEF.md
# Integer to Compact Floating-Point Converter

This block turns a 12-bit two's-complement integer into an 8-bit floating-point code. The code is delivered as three separate fields: a 1-bit sign S, a 3-bit exponent E and a 4-bit significand F. The encoded value is (-1)^S × F × 2^E. The block is used wherever a wide integer count must be squeezed into one byte and a small relative error is acceptable.

The path is purely combinational and has three stages. The first stage takes the magnitude of the input. The second stage runs a priority search for the leading one; this search picks both the exponent and the four significand bits, plus one round bit. The third stage rounds half up. A carry out of the significand moves into the exponent, and a result past the top of the range clamps to the largest code. The most negative input has no 12-bit positive magnitude and is handled on a path of its own.

Top module: `int_to_minifloat`

## Requirements
- R1: The sign output equals input bit 11: 0 for zero or positive inputs, 1 for negative inputs.
- R2: A negative input is converted through its two's-complement magnitude, so -x and +x give the same E and F for every x from 1 to 2047.
- R3: When the magnitude is 16 or more, E is 8 minus the count of leading zeros in the 12-bit magnitude, F is the four bits that start at the leading one, and the bit just below them is the round bit.
- R4: When the magnitude is below 16, E is 0 and F is the low four magnitude bits, with no rounding; input 0 gives S=0, E=0, F=0.
- R5: A round bit of 0 leaves E and F as selected, so the lower bits are truncated (1792 gives E=7, F=14).
- R6: A round bit of 1 with F below 15 increments F (42 gives E=2, F=11).
- R7: A round bit of 1 with F equal to 15 and E below 7 sets F to 8 and increments E (31 gives E=2, F=8).
- R8: A round bit of 1 with F equal to 15 and E equal to 7 clamps the result to E=7, F=15 (1984 and 2047 give E=7, F=15).
- R9: Input -2048 gives S=1, E=7, F=15.
- R10: For every one of the 4096 inputs, F × 2^E is the representable magnitude nearest to the input magnitude. The representable set is E=0 with any F, and E>0 with F from 8 to 15. A tie resolves to the larger value, and any value above 1920 maps to 1920.
- R11: The outputs depend on the current input alone and are valid in the same cycle the input is applied, with no clock or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 12 | Two's-complement integer to convert |
| sign_o | output | 1 | Sign of the code |
| exp_o | output | 3 | Exponent of the code |
| frac_o | output | 4 | Significand of the code |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies between din and the three outputs. The bench applies each input just after a rising edge of its pacing clock and samples the outputs at the following falling edge. By then the combinational path has settled, and no check depends on process order at an edge. The spot-value table, the directed round and clamp cases, and the full 4096-value sweep all follow this same schedule.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int DEF_IN_W  = 12;
  localparam int DEF_MAN_W = 4;

  typedef enum logic [1:0] {
    RND_KEEP  = 2'd0,
    RND_INC   = 2'd1,
    RND_CARRY = 2'd2,
    RND_SAT   = 2'd3
  } rnd_act_t;
endpackage

// File: rtl/fpc_magnitude.sv
module fpc_magnitude #(
  parameter int IN_W = 12
) (
  input  logic [IN_W-1:0] din,
  output logic            neg,
  output logic            is_min,
  output logic [IN_W-1:0] mag
);
  always_comb begin
    neg    = din[IN_W-1];
    is_min = neg && (din[IN_W-2:0] == '0);
    mag    = neg ? (~din + 1'b1) : din;
  end

  always_comb begin
    if (!$isunknown(din)) begin
      assert_mag_fits_R2: assert (is_min || !mag[IN_W-1])
        else $error("magnitude has top bit set for non-minimum input");
    end
  end
endmodule

// File: rtl/fpc_normalize.sv
module fpc_normalize #(
  parameter int IN_W  = 12,
  parameter int MAN_W = 4,
  parameter int EXP_W = 3
) (
  input  logic [IN_W-1:0]  mag,
  input  logic             is_min,
  output logic [EXP_W-1:0] e_raw,
  output logic [MAN_W-1:0] f_raw,
  output logic             rbit
);
  localparam int POS_W = $clog2(IN_W);

  logic [POS_W-1:0] lead_pos;
  logic             lead_hit;
  logic [IN_W-1:0]  shifted;

  always_comb begin
    lead_pos = '0;
    lead_hit = 1'b0;
    for (int i = 0; i < IN_W; i++) begin
      if (mag[i]) begin
        lead_pos = POS_W'(i);
        lead_hit = 1'b1;
      end
    end
  end

  always_comb begin
    shifted = '0;
    e_raw   = '0;
    f_raw   = mag[MAN_W-1:0];
    rbit    = 1'b0;
    if (is_min) begin
      e_raw = '1;
      f_raw = '1;
      rbit  = 1'b1;
    end else if (lead_hit && (lead_pos >= POS_W'(MAN_W))) begin
      shifted = mag >> (lead_pos - POS_W'(MAN_W));
      f_raw   = shifted[MAN_W:1];
      rbit    = shifted[0];
      e_raw   = EXP_W'(lead_pos - POS_W'(MAN_W - 1));
    end
  end

  always_comb begin
    if (!$isunknown({mag, is_min})) begin
      assert_norm_lead_R3: assert (e_raw == '0 || f_raw[MAN_W-1])
        else $error("nonzero exponent with unnormalized significand");
    end
  end
endmodule

// File: rtl/fpc_round.sv
module fpc_round
  import fpc_pkg::*;
#(
  parameter int MAN_W = 4,
  parameter int EXP_W = 3
) (
  input  logic [EXP_W-1:0] e_raw,
  input  logic [MAN_W-1:0] f_raw,
  input  logic             rbit,
  output logic [EXP_W-1:0] e_out,
  output logic [MAN_W-1:0] f_out
);
  localparam int VAL_W = MAN_W + (1 << EXP_W);

  rnd_act_t act;

  always_comb begin
    if (!rbit)                 act = RND_KEEP;
    else if (f_raw != '1)      act = RND_INC;
    else if (e_raw != '1)      act = RND_CARRY;
    else                       act = RND_SAT;
  end

  always_comb begin
    e_out = e_raw;
    f_out = f_raw;
    unique case (act)
      RND_KEEP:  ;
      RND_INC:   f_out = f_raw + 1'b1;
      RND_CARRY: begin
        f_out = {1'b1, {(MAN_W-1){1'b0}}};
        e_out = e_raw + 1'b1;
      end
      RND_SAT: begin
        f_out = '1;
        e_out = '1;
      end
    endcase
  end

  logic [VAL_W-1:0] v_in, v_out;
  always_comb begin
    v_in  = VAL_W'(f_raw) << e_raw;
    v_out = VAL_W'(f_out) << e_out;
    if (!$isunknown({e_raw, f_raw, rbit})) begin
      assert_no_decrease_R6: assert (v_out >= v_in)
        else $error("rounding lowered the value");
      if (e_out != e_raw) begin
        assert_carry_form_R7: assert (f_out == {1'b1, {(MAN_W-1){1'b0}}} && rbit)
          else $error("exponent moved without carry form");
      end
      if (!rbit) begin
        assert_trunc_hold_R5: assert (v_out == v_in)
          else $error("value changed with clear round bit");
      end
    end
  end
endmodule

// File: rtl/int_to_minifloat.sv
module int_to_minifloat #(
  parameter int IN_W  = fpc_pkg::DEF_IN_W,
  parameter int MAN_W = fpc_pkg::DEF_MAN_W,
  localparam int EXP_W = $clog2(IN_W - MAN_W)
) (
  input  logic [IN_W-1:0]  din,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [MAN_W-1:0] frac_o
);
  logic            neg, is_min, rbit;
  logic [IN_W-1:0] mag;
  logic [EXP_W-1:0] e_raw;
  logic [MAN_W-1:0] f_raw;

  fpc_magnitude #(.IN_W(IN_W)) u_mag (
    .din(din), .neg(neg), .is_min(is_min), .mag(mag)
  );

  fpc_normalize #(.IN_W(IN_W), .MAN_W(MAN_W), .EXP_W(EXP_W)) u_norm (
    .mag(mag), .is_min(is_min), .e_raw(e_raw), .f_raw(f_raw), .rbit(rbit)
  );

  fpc_round #(.MAN_W(MAN_W), .EXP_W(EXP_W)) u_rnd (
    .e_raw(e_raw), .f_raw(f_raw), .rbit(rbit), .e_out(exp_o), .f_out(frac_o)
  );

  assign sign_o = neg;

  always_comb begin
    if (!$isunknown(din)) begin
      if (din == '0) begin
        assert_zero_code_R4: assert (!sign_o && exp_o == '0 && frac_o == '0)
          else $error("zero input gave nonzero code");
      end
      if (is_min) begin
        assert_min_code_R9: assert (sign_o && exp_o == '1 && frac_o == '1)
          else $error("most negative input not at maximum code");
      end
    end
  end
endmodule

// File: tb/sim_int_to_minifloat.sv
module sim_int_to_minifloat;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NSPOT      = 10;

  // {din, S, E, F}
  localparam logic [19:0] SPOT [NSPOT] = '{
    {12'd0,    1'b0, 3'd0, 4'd0},
    {12'd2047, 1'b0, 3'd7, 4'd15},
    {12'h800,  1'b1, 3'd7, 4'd15},
    {12'hD4B,  1'b1, 3'd6, 4'd11},
    {12'd6,    1'b0, 3'd0, 4'd6},
    {12'd79,   1'b0, 3'd3, 4'd10},
    {12'd1835, 1'b0, 3'd7, 4'd14},
    {12'hC17,  1'b1, 3'd7, 4'd8},
    {12'd239,  1'b0, 3'd4, 4'd15},
    {12'd1001, 1'b0, 3'd7, 4'd8}
  };

  logic        clk = 1'b0;
  logic [11:0] din = '0;
  logic        sign_o;
  logic [2:0]  exp_o;
  logic [3:0]  frac_o;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  int_to_minifloat u0 (.din(din), .sign_o(sign_o), .exp_o(exp_o), .frac_o(frac_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ref_code(input logic [11:0] x);
    int v, best, bestv, d, bd;
    logic s;
    s = x[11];
    v = s ? 4096 - int'(x) : int'(x);
    best = 0; bestv = 0; bd = 1 << 20;
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 16; f++) begin
        if (e == 0 || f >= 8) begin
          d = (v > (f << e)) ? v - (f << e) : (f << e) - v;
          if (d <= bd && (f << e) >= bestv) begin
            bd = d; bestv = f << e; best = e * 16 + f;
          end
        end
      end
    end
    return {s, 7'(best)};
  endfunction

  task automatic apply_check(input string tag, input logic [11:0] x, input logic [7:0] exp_c);
    @(posedge clk);
    din = x;
    @(negedge clk);
    n_chk++;
    if ({sign_o, exp_o, frac_o} !== exp_c) begin
      n_fail++;
      $display("FAIL %s din=%0d actual S=%0b E=%0d F=%0d expected S=%0b E=%0d F=%0d",
               tag, $signed(x), sign_o, exp_o, frac_o, exp_c[7], exp_c[6:4], exp_c[3:0]);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG && !done) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog R11 actual cycles=%0d expected below %0d", cyc, WATCHDOG);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    // spot values covering R1, R3, R9 and R10
    for (int k = 0; k < NSPOT; k++)
      apply_check("R10 spot R1 R3 R9", SPOT[k][19:8], SPOT[k][7:0]);
    // R4 small magnitudes and zero
    apply_check("R4", 12'd0,  {1'b0, 3'd0, 4'd0});
    apply_check("R4", 12'd15, {1'b0, 3'd0, 4'd15});
    apply_check("R3", 12'd16, {1'b0, 3'd1, 4'd8});
    // R5 truncation
    apply_check("R5", 12'd1792, {1'b0, 3'd7, 4'd14});
    apply_check("R5", 12'd40,   {1'b0, 3'd2, 4'd10});
    // R6 increment
    apply_check("R6", 12'd42, {1'b0, 3'd2, 4'd11});
    // R7 carry into exponent
    apply_check("R7", 12'd31, {1'b0, 3'd2, 4'd8});
    // R8 clamp
    apply_check("R8", 12'd1984, {1'b0, 3'd7, 4'd15});
    apply_check("R8", 12'd2047, {1'b0, 3'd7, 4'd15});
    // R2 negative magnitude and R1 sign
    apply_check("R2", 12'hFD6, {1'b1, 3'd2, 4'd11});
    apply_check("R2", 12'hFFF, {1'b1, 3'd0, 4'd1});
    apply_check("R9", 12'h800, {1'b1, 3'd7, 4'd15});
    // R10 full sweep (also R1, R11)
    for (int v = 0; v < 4096; v++)
      apply_check("R10 sweep", 12'(v), ref_code(12'(v)));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule